// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to a 16-bit segment base that has been shifted left by four bit positions. It holds four segment base registers, one each for code, data, stack and extra data. A write port loads these registers, and a combinational read port returns any of them.

Each address request gives an access kind and a 16-bit offset. It can also give a segment override. The access kind selects the segment implicitly:

- Instruction fetches always use the code base.
- Stack references always use the stack base.
- Extra-data accesses always use the extra base.
- Ordinary data accesses use the data base, unless the override field names another register.

The physical address appears one clock cycle after the request, on a registered output with a valid flag. Any carry out of the top bit is dropped, so addresses wrap within a 1 MiB space.

A segment write and a request in the same cycle do not interfere. The request sees the register contents from before the write, and the new contents apply from the following cycle. This lets a base change and an access that still belongs to the old base be issued together.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, the code base register reads 0xFFFF, the data, stack and extra base registers read 0x0000, and `pa_valid` is low.
- R2: When `seg_wr_en` is high at a rising edge, the register named by `seg_wr_sel` takes `seg_wr_data`. The register index encoding is code=0, data=1, stack=2, extra=3. `seg_rd_data` shows the register named by `seg_rd_sel` combinationally, using the same encoding.
- R3: An instruction fetch (`req_kind`=0) uses the code base, whatever the override inputs are.
- R4: A stack reference (`req_kind`=1) uses the stack base, whatever the override inputs are.
- R5: A data access (`req_kind`=2) uses the data base when `req_ovr_en` is low. When `req_ovr_en` is high, it uses the register named by `req_ovr_sel`, with the R2 encoding.
- R6: An extra-data access (`req_kind`=3) uses the extra base, whatever the override inputs are.
- R7: The address is (base × 16 + offset) modulo 2^20. A carry out of bit 19 is discarded.
- R8: `pa_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. Requests in consecutive cycles give results in consecutive cycles.
- R9: When a request and a segment write happen in the same cycle, the address uses the register value from before the write. The written value applies from the next cycle.
- R10: In a cycle where `pa_valid` is low, `pa_addr` keeps its previous value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Index of the register to write |
| seg_wr_data | input | 16 | Value to write |
| seg_rd_sel | input | 2 | Index of the register to read back |
| seg_rd_data | output | 16 | Contents of the selected register |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind: fetch=0, stack=1, data=2, extra-data=3 |
| req_ovr_en | input | 1 | Enables the segment override (data accesses only) |
| req_ovr_sel | input | 2 | Override register index |
| req_offset | input | 16 | Offset within the segment |
| pa_valid | output | 1 | Physical address valid |
| pa_addr | output | 20 | Physical address |

## Verification
Some rules are checked by assertions on every cycle:

- the one-cycle latency of the valid flag;
- the hold of the address while it is idle;
- the landing of each write in its register;
- the fixed register choice for fetch, stack and extra-data accesses;
- the low address bits coming straight from the offset.

Other behaviour only shows up in the bench's scenarios. These include:

- the full sum with wrap past 1 MiB;
- the effect of each override value on data accesses;
- the reset values seen through the read port;
- a request in the same cycle as a write picking up the old base;
- long runs of back-to-back requests matching a scoreboard in order.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

    // Register index encoding shared by the write, read and override fields.
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    // Access kind presented with a request.
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_DATA  = 2'd2,
        ACC_XDATA = 2'd3
    } acc_kind_e;

    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import segaddr_pkg::*;
#(
    parameter int              SEG_W    = 16,
    parameter logic [SEG_W-1:0] CODE_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [SEG_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [SEG_W-1:0] rd_b_data
);

    logic [SEG_W-1:0] regs [NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL =
            (i == int'(SEG_CODE)) ? CODE_RST : '0;
        logic [SEG_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                q <= wr_data;
            end
        end

        assign regs[i] = q;
    end

    assign rd_a_data = regs[rd_a_sel];
    assign rd_b_data = regs[rd_b_sel];

    // R2: a write lands in exactly the named register on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_sel)] == $past(wr_data)));

endmodule

// File: rtl/seg_select.sv
module seg_select
    import segaddr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       kind,
    input  logic             ovr_en,
    input  logic [SEL_W-1:0] ovr_sel,
    output logic [SEL_W-1:0] seg_idx
);

    acc_kind_e kind_e;
    assign kind_e = acc_kind_e'(kind);

    always_comb begin
        unique case (kind_e)
            ACC_FETCH: seg_idx = SEG_CODE;
            ACC_STACK: seg_idx = SEG_STACK;
            ACC_XDATA: seg_idx = SEG_EXTRA;
            ACC_DATA:  seg_idx = ovr_en ? ovr_sel : SEL_W'(SEG_DATA);
            default:   seg_idx = SEG_DATA;
        endcase
    end

    // R3: fetches are tied to the code base
    p_fetch_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd0) |-> (seg_idx == 2'd0));

    // R4: stack references are tied to the stack base
    p_stack_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd1) |-> (seg_idx == 2'd2));

    // R6: extra-data accesses are tied to the extra base
    p_xdata_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd3) |-> (seg_idx == 2'd3));

    // R5: a data access without override picks the data base
    p_data_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == 2'd2) && !ovr_en) |-> (seg_idx == 2'd1));

endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEG_W-1:0] base,
    input  logic [OFF_W-1:0] offset,
    output logic             out_valid,
    output logic [PA_W-1:0]  out_addr
);

    logic [PA_W:0]   sum_full;
    logic [PA_W-1:0] sum_wrap;

    always_comb begin
        sum_full = {1'b0, base, {SHIFT{1'b0}}} + (PA_W + 1)'(offset);
        sum_wrap = sum_full[PA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= sum_wrap;
            end
        end
    end

    // R8: one result per request, exactly one cycle later
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: address holds while no request is in flight
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import segaddr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic [1:0]       seg_rd_sel,
    output logic [SEG_W-1:0] seg_rd_data,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_ovr_en,
    input  logic [1:0]       req_ovr_sel,
    input  logic [OFF_W-1:0] req_offset,
    output logic             pa_valid,
    output logic [PA_W-1:0]  pa_addr
);

    logic [SEL_W-1:0] sel_idx;
    logic [SEG_W-1:0] sel_base;

    seg_select u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (req_kind),
        .ovr_en  (req_ovr_en),
        .ovr_sel (req_ovr_sel),
        .seg_idx (sel_idx)
    );

    seg_regfile #(
        .SEG_W    (SEG_W),
        .CODE_RST ({SEG_W{1'b1}})
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (seg_wr_en),
        .wr_sel    (seg_wr_sel),
        .wr_data   (seg_wr_data),
        .rd_a_sel  (sel_idx),
        .rd_a_data (sel_base),
        .rd_b_sel  (seg_rd_sel),
        .rd_b_data (seg_rd_data)
    );

    addr_adder #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .base      (sel_base),
        .offset    (req_offset),
        .out_valid (pa_valid),
        .out_addr  (pa_addr)
    );

    // R7: the low SHIFT address bits come from the offset alone
    p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pa_valid |-> (pa_addr[SHIFT-1:0] == $past(req_offset[SHIFT-1:0])));

endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [19:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic [1:0]  seg_rd_sel = '0;
    logic [15:0] seg_rd_data;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_sel = '0;
    logic [15:0] req_offset = '0;
    logic        pa_valid;
    logic [19:0] pa_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t exp_q[$];
    logic [15:0] shadow [4];
    logic [19:0] last_addr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .seg_rd_sel  (seg_rd_sel),
        .seg_rd_data (seg_rd_data),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_ovr_en  (req_ovr_en),
        .req_ovr_sel (req_ovr_sel),
        .req_offset  (req_offset),
        .pa_valid    (pa_valid),
        .pa_addr     (pa_addr)
    );

    // Reference model written from the requirements.
    function automatic logic [1:0] pick_seg(input logic [1:0] kind,
                                            input bit oe,
                                            input logic [1:0] os);
        case (kind)
            2'd0:    return 2'd0;
            2'd1:    return 2'd2;
            2'd3:    return 2'd3;
            default: return oe ? os : 2'd1;
        endcase
    endfunction

    function automatic logic [19:0] form_addr(input logic [15:0] base,
                                              input logic [15:0] off);
        logic [20:0] full;
        full = {1'b0, base, 4'h0} + {5'h0, off};
        return full[19:0];
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [19:0] act, input logic [19:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            if (exp_q.size() != 0)
                check(1'b0, "R8 results missing", 20'(exp_q.size()), 20'h0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
    task automatic step(input bit we, input logic [1:0] ws, input logic [15:0] wd,
                        input bit rv, input logic [1:0] kind, input bit oe,
                        input logic [1:0] os, input logic [15:0] off,
                        input string tag);
        exp_t e;
        seg_wr_en   = we;
        seg_wr_sel  = ws;
        seg_wr_data = wd;
        req_valid   = rv;
        req_kind    = kind;
        req_ovr_en  = oe;
        req_ovr_sel = os;
        req_offset  = off;
        if (rv) begin
            e.addr = form_addr(shadow[pick_seg(kind, oe, os)], off);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        if (we) shadow[ws] = wd;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "idle");
    endtask

    task automatic req(input logic [1:0] kind, input bit oe,
                       input logic [1:0] os, input logic [15:0] off,
                       input string tag);
        step(1'b0, 2'd0, 16'h0, 1'b1, kind, oe, os, off, tag);
    endtask

    task automatic wr(input logic [1:0] ws, input logic [15:0] wd);
        step(1'b1, ws, wd, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "write");
    endtask

    task automatic rd_check(input logic [1:0] sel, input logic [15:0] expv,
                            input string tag);
        seg_rd_sel = sel;
        #1;
        check(seg_rd_data == expv, tag, 20'(seg_rd_data), 20'(expv));
    endtask

    // Monitor: compares each result against the scoreboard, and checks hold.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (pa_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", pa_addr, 20'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(pa_addr == e.addr, e.tag, pa_addr, e.addr);
                end
                last_addr = pa_addr;
            end else begin
                check(pa_addr == last_addr, "R10 address hold", pa_addr, last_addr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 20'h0, 20'h0);
        report();
    end

    initial begin
        shadow[0] = 16'hFFFF;
        shadow[1] = 16'h0000;
        shadow[2] = 16'h0000;
        shadow[3] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset contents and idle output
        check(pa_valid == 1'b0, "R1 valid low after reset", 20'(pa_valid), 20'h0);
        check(pa_addr == 20'h0, "R1 address zero after reset", pa_addr, 20'h0);
        rd_check(2'd0, 16'hFFFF, "R1 code reset");
        rd_check(2'd1, 16'h0000, "R1 data reset");
        rd_check(2'd2, 16'h0000, "R1 stack reset");
        rd_check(2'd3, 16'h0000, "R1 extra reset");
        @(negedge clk);

        // R7 with reset values: code base 0xFFFF wraps past 1 MiB
        req(2'd0, 1'b0, 2'd0, 16'h0010, "R7 fetch wrap from reset base");
        idle();

        // R2: load every register and read back
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'h2000);
        wr(2'd2, 16'h8000);
        wr(2'd3, 16'hABCD);
        rd_check(2'd0, 16'h1234, "R2 code readback");
        rd_check(2'd1, 16'h2000, "R2 data readback");
        rd_check(2'd2, 16'h8000, "R2 stack readback");
        rd_check(2'd3, 16'hABCD, "R2 extra readback");

        // R3, R4, R6: override ignored for fixed kinds
        req(2'd0, 1'b1, 2'd1, 16'h0010, "R3 fetch ignores override");
        req(2'd1, 1'b1, 2'd3, 16'hFFFE, "R4 stack ignores override");
        req(2'd3, 1'b1, 2'd0, 16'h0001, "R6 extra-data ignores override");
        idle();

        // R5: default and every override value
        req(2'd2, 1'b0, 2'd3, 16'h0005, "R5 data default");
        for (int s = 0; s < 4; s++)
            req(2'd2, 1'b1, 2'(s), 16'h0100, "R5 data override");
        idle();

        // R7: wrap modulo 2^20
        wr(2'd1, 16'hFFFF);
        req(2'd2, 1'b0, 2'd0, 16'hFFFF, "R7 data wrap max");
        req(2'd2, 1'b0, 2'd0, 16'h0010, "R7 data wrap to zero");

        // R9: write and request together use the old base
        step(1'b1, 2'd1, 16'h0040, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0003,
             "R9 same-cycle write uses old base");
        req(2'd2, 1'b0, 2'd0, 16'h0003, "R9 new base next cycle");
        idle();
        idle();

        // R8: long back-to-back run with a mix of kinds
        for (int i = 0; i < 24; i++)
            req(2'(i % 4), i[2], 2'(i / 3), 16'(i * 16'h0913), "R8 back-to-back");
        idle();
        idle();
        report();
    end

endmodule